// File: doc/BRIEF.md
# ADC Self-Calibration Sequencer

This block runs the calibration pass of an analog-to-digital converter when software asks for one. Software writes a control word that carries a start flag and two mode flags: one selects offset calibration for differential inputs instead of single-ended inputs, the other adds a linearity pass. The linearity pass runs alongside the offset pass. The start flag reads back as set for the whole run and drops by itself when the run ends. A run is accepted only while the converter is powered and not enabled. The mode flags are taken from the same write that sets the start flag.

The run length is counted in converter clock cycles. An offset-only run lasts the offset time. A run with linearity lasts the longer of the offset and linearity times. Both times are parameters, so a bench can shorten them. The analog algorithm is not modelled. Results come from a pseudo-value generator keyed to the number of completed runs. At the end of a linearity run, six factor words are handed to the shadow-register transfer block with a one-cycle push strobe, and six ready flags are set.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset, `ctrl_rdata`, `calfact` and `lin_words` are all zero and `lin_push` is low.
- R2: A write with bit 31 set that is accepted makes bit 31 of `ctrl_rdata` read 1 from the next cycle. For an offset-only run it stays 1 for exactly `OFS_CYCLES` cycles and then clears by itself.
- R3: When bit 16 of the accepted write is set, bit 31 stays 1 for exactly max(`OFS_CYCLES`, `LIN_CYCLES`) cycles.
- R4: A start write is accepted only when `conv_powered` is 1 and `conv_enabled` is 0. Otherwise bit 31 stays 0, `calfact` is unchanged and `lin_push` stays low.
- R5: A write while idle loads bit 30 (differential mode) and bit 16 (linearity mode), which read back at the same positions. Any write while bit 31 reads 1 changes neither mode bit nor the run length.
- R6: At the end of run number k (counted from 1 after reset), let p = k × 0x9E3779B1 mod 2^32. The offset result p[OFS_W-1:0] goes to `calfact[OFS_W-1:0]` when the differential bit was 0, or to `calfact[2*OFS_W-1:OFS_W]` when it was 1. The other field keeps its value.
- R7: At the end of a linearity run, `lin_push` is 1 for exactly one cycle, in the first cycle that bit 31 reads 0. Word i (i = 0..5) at `lin_words[i*LIN_W +: LIN_W]` equals (p + (i+1) × 0x7F4A7C15)[LIN_W-1:0]. Bits 27:22 of `ctrl_rdata` (the ready flags, one per word, word i at bit 22+i) all read 1.
- R8: Accepting a linearity run clears ready bits 27:22 from the next cycle. An offset-only run leaves them unchanged and never raises `lin_push`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: bit 31 start, bit 30 differential, bit 16 linearity |
| conv_powered | input | 1 | Converter is out of power-down |
| conv_enabled | input | 1 | Converter is enabled for conversions |
| ctrl_rdata | output | 32 | Readback: bit 31 busy/start, bit 30, bit 16, bits 27:22 ready flags |
| calfact | output | 2*OFS_W | Offset results: differential field high, single-ended field low |
| lin_push | output | 1 | One-cycle strobe handing the linearity words to the shadow store |
| lin_words | output | 6*LIN_W | Six linearity factor words, word 0 lowest |

## Verification
The bench counts how many cycles the start bit is held for each mode. A sequencer that clears the bit one cycle early or late, or that uses the offset time for a linearity run, shows up as a wrong count. It writes into a running calibration with inverted mode bits and a fresh start bit. A design that let that write through would flip the readback mode bits or restart the counter, which would stretch the run. Start writes are made with the converter unpowered or already enabled. A design that did not gate on these conditions would raise the busy bit or change a result field. Offset-only runs are placed between linearity runs. A design that cleared the ready flags or pushed words on an offset run would be caught, as would one that wrote the offset result into the wrong single-ended or differential field.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int CTRL_W       = 32;
  localparam int BIT_START    = 31;
  localparam int BIT_DIFF     = 30;
  localparam int BIT_LIN      = 16;
  localparam int RDY_LSB      = 22;
  localparam int NUM_LIN_WORD = 6;

  localparam logic [31:0] GEN_MUL  = 32'h9E37_79B1;
  localparam logic [31:0] GEN_STEP = 32'h7F4A_7C15;

  typedef struct packed {
    logic diff;
    logic lin;
  } cal_mode_t;
endpackage

// File: rtl/cal_timer.sv
module cal_timer #(
  parameter int MAXC = 16384,
  parameter int CW   = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy,
  output logic          done
);
  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (!run_q && load) begin
      run_d = 1'b1;
      cnt_d = load_val - CW'(1);
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = run_q;
  assign done = run_q && (cnt_q == '0);

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < CW'(MAXC)));
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int OFS_LEN = 20,
  parameter int RUN_LEN = 16384,
  parameter int CW      = $clog2(RUN_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              powered,
  input  logic              enabled,
  input  logic              busy,
  input  logic              done,
  output logic              accept,
  output logic [CW-1:0]     load_val,
  output cal_mode_t         mode,
  output logic [NUM_LIN_WORD-1:0] ready,
  output logic [CTRL_W-1:0] rdata
);
  cal_mode_t               mode_q, mode_d;
  logic [NUM_LIN_WORD-1:0] rdy_q, rdy_d;
  logic                    wr_idle;

  assign wr_idle  = we && !busy;
  assign accept   = wr_idle && wdata[BIT_START] && powered && !enabled;
  assign load_val = wdata[BIT_LIN] ? CW'(RUN_LEN) : CW'(OFS_LEN);

  always_comb begin
    mode_d = mode_q;
    rdy_d  = rdy_q;
    if (wr_idle) begin
      mode_d.diff = wdata[BIT_DIFF];
      mode_d.lin  = wdata[BIT_LIN];
    end
    if (accept && wdata[BIT_LIN]) rdy_d = '0;
    else if (done && mode_q.lin)  rdy_d = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rdy_q  <= '0;
    end else begin
      mode_q <= mode_d;
      rdy_q  <= rdy_d;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[BIT_START] = busy;
    rdata[BIT_DIFF]  = mode_q.diff;
    rdata[BIT_LIN]   = mode_q.lin;
    rdata[RDY_LSB +: NUM_LIN_WORD] = rdy_q;
  end

  assign mode  = mode_q;
  assign ready = rdy_q;

  // R5: mode flags hold still across a running calibration
  a_r5_modes_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mode_q.diff) && $stable(mode_q.lin)));
endmodule

// File: rtl/cal_results.sv
module cal_results
  import cal_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int LIN_W = 30
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          done,
  input  cal_mode_t                     mode,
  output logic [2*OFS_W-1:0]            calfact,
  output logic                          push,
  output logic [NUM_LIN_WORD*LIN_W-1:0] words
);
  logic [31:0]                   runs_q, runs_d;
  logic [31:0]                   seed;
  logic [OFS_W-1:0]              se_q, se_d, df_q, df_d;
  logic [NUM_LIN_WORD*LIN_W-1:0] w_q, w_d, w_gen;
  logic                          push_d, push_q;

  assign seed = (runs_q + 32'd1) * GEN_MUL;

  for (genvar gi = 0; gi < NUM_LIN_WORD; gi++) begin : g_word
    logic [31:0] sum;
    assign sum = seed + (32'(gi + 1) * GEN_STEP);
    assign w_gen[gi*LIN_W +: LIN_W] = sum[LIN_W-1:0];
  end

  always_comb begin
    runs_d = runs_q;
    se_d   = se_q;
    df_d   = df_q;
    w_d    = w_q;
    push_d = 1'b0;
    if (done) begin
      runs_d = runs_q + 32'd1;
      if (mode.diff) df_d = seed[OFS_W-1:0];
      else           se_d = seed[OFS_W-1:0];
      if (mode.lin) begin
        w_d    = w_gen;
        push_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runs_q <= '0;
      se_q   <= '0;
      df_q   <= '0;
      w_q    <= '0;
      push_q <= 1'b0;
    end else begin
      runs_q <= runs_d;
      se_q   <= se_d;
      df_q   <= df_d;
      w_q    <= w_d;
      push_q <= push_d;
    end
  end

  assign calfact = {df_q, se_q};
  assign words   = w_q;
  assign push    = push_q;

  // R6: offset fields only move on a completion edge
  a_r6_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done) |-> $stable(calfact));
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import cal_pkg::*;
#(
  parameter int OFS_CYCLES = 20,
  parameter int LIN_CYCLES = 16384,
  parameter int OFS_W      = 8,
  parameter int LIN_W      = 30
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctrl_we,
  input  logic [31:0]                   ctrl_wdata,
  input  logic                          conv_powered,
  input  logic                          conv_enabled,
  output logic [31:0]                   ctrl_rdata,
  output logic [2*OFS_W-1:0]            calfact,
  output logic                          lin_push,
  output logic [NUM_LIN_WORD*LIN_W-1:0] lin_words
);
  localparam int RUN_LEN = (LIN_CYCLES > OFS_CYCLES) ? LIN_CYCLES : OFS_CYCLES;
  localparam int CW      = $clog2(RUN_LEN + 1);

  logic                    accept, busy, done;
  logic [CW-1:0]           load_val;
  cal_mode_t               mode;
  logic [NUM_LIN_WORD-1:0] ready;

  cal_ctrl #(.OFS_LEN(OFS_CYCLES), .RUN_LEN(RUN_LEN), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
    .powered(conv_powered), .enabled(conv_enabled), .busy(busy), .done(done),
    .accept(accept), .load_val(load_val), .mode(mode), .ready(ready),
    .rdata(ctrl_rdata)
  );

  cal_timer #(.MAXC(RUN_LEN), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(load_val),
    .busy(busy), .done(done)
  );

  cal_results #(.OFS_W(OFS_W), .LIN_W(LIN_W)) u_res (
    .clk(clk), .rst_n(rst_n), .done(done), .mode(mode),
    .calfact(calfact), .push(lin_push), .words(lin_words)
  );

  // R4: a run only begins from a powered, disabled converter
  a_r4_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(conv_powered) && !$past(conv_enabled)));
  // R7: push arrives with all ready flags raised
  a_r7_push_ready: assert property (@(posedge clk) disable iff (!rst_n)
    lin_push |-> (&ready));
  // R7: push coincides with the run ending
  a_r7_push_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    lin_push |-> $fell(busy));
  // R7: push is a single-cycle strobe
  a_r7_push_single: assert property (@(posedge clk) disable iff (!rst_n)
    lin_push |=> !lin_push);
endmodule

// File: tb/adc_cal_seq_bench.sv
module adc_cal_seq_bench;
  localparam int OFS = 20;
  localparam int LIN = 300;
  localparam int OW  = 8;
  localparam int LW  = 30;
  localparam int RUN = (LIN > OFS) ? LIN : OFS;

  logic              clk, rst_n, we, pw, en;
  logic [31:0]       wdata, rdata;
  logic [2*OW-1:0]   calfact;
  logic              push;
  logic [6*LW-1:0]   words;

  adc_cal_seq #(.OFS_CYCLES(OFS), .LIN_CYCLES(LIN), .OFS_W(OW), .LIN_W(LW)) u_adc_cal_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_we(we), .ctrl_wdata(wdata),
    .conv_powered(pw), .conv_enabled(en), .ctrl_rdata(rdata),
    .calfact(calfact), .lin_push(push), .lin_words(words)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // vector: diff, lin, powered, enabled, poke-while-busy
  typedef struct packed { logic diff; logic lin; logic pw; logic en; logic poke; } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  logic [OW-1:0] exp_se, exp_df;
  logic [5:0]    exp_rdy;
  logic [6*LW-1:0] exp_words;
  int            runs;

  task automatic run_vec(vec_t v);
    logic [2*OW-1:0] cf_before;
    logic [31:0] p, s;
    int n, cnt;
    bit acc, push_seen;
    cf_before = calfact;
    acc = v.pw && !v.en;
    n = v.lin ? RUN : OFS;
    @(negedge clk);
    pw = v.pw; en = v.en; we = 1'b1;
    wdata = 32'h0; wdata[31] = 1'b1; wdata[30] = v.diff; wdata[16] = v.lin;
    @(negedge clk);
    we = 1'b0;
    chk("R2/R4 start bit", rdata[31], acc);
    chk("R5 diff readback", rdata[30], v.diff);
    chk("R5 lin readback", rdata[16], v.lin);
    if (!acc) begin
      repeat (3) @(negedge clk);
      chk("R4 rejected idle", rdata[31], 1'b0);
      chk("R4 calfact unchanged", calfact, cf_before);
      chk("R4 no push", push, 1'b0);
      return;
    end
    chk("R8 ready during run", rdata[27:22], v.lin ? 6'h00 : exp_rdy);
    if (v.lin) exp_rdy = 6'h00;
    cnt = 0; push_seen = 0;
    while (rdata[31] && cnt < n + 5) begin
      if (v.poke && cnt == 2) begin
        we = 1'b1;
        wdata = 32'h0; wdata[31] = 1'b1; wdata[30] = ~v.diff; wdata[16] = ~v.lin;
        @(negedge clk);
        we = 1'b0;
        cnt++;
        chk("R5 diff frozen", rdata[30], v.diff);
        chk("R5 lin frozen", rdata[16], v.lin);
      end else begin
        if (push) push_seen = 1;
        @(negedge clk);
        cnt++;
      end
    end
    chk(v.lin ? "R3 linearity run length" : "R2 offset run length", cnt, n);
    chk("R7 no push while busy", push_seen, 1'b0);
    runs++;
    p = runs * 32'h9E37_79B1;
    if (v.diff) exp_df = p[OW-1:0]; else exp_se = p[OW-1:0];
    chk("R6 offset fields", calfact, {exp_df, exp_se});
    chk(v.lin ? "R7 push at end" : "R8 no push offset-only", push, v.lin);
    if (v.lin) begin
      exp_rdy = 6'h3F;
      for (int i = 0; i < 6; i++) begin
        s = p + (i + 1) * 32'h7F4A_7C15;
        exp_words[i*LW +: LW] = s[LW-1:0];
      end
      chk("R7 factor words", words[63:0], exp_words[63:0]);
      chk("R7 factor words hi", words[6*LW-1:64], exp_words[6*LW-1:64]);
    end
    chk("R7/R8 ready flags", rdata[27:22], exp_rdy);
    @(negedge clk);
    chk("R7 push single cycle", push, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; wdata = '0; pw = 1'b1; en = 1'b0;
    exp_se = '0; exp_df = '0; exp_rdy = '0; exp_words = '0; runs = 0;
    repeat (3) @(negedge clk);
    chk("R1 rdata reset", rdata, 32'h0);
    chk("R1 calfact reset", calfact, '0);
    chk("R1 push reset", push, 1'b0);
    chk("R1 words reset", words[63:0], 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (VECS[k]) run_vec(VECS[k]);
    // R8: offset-only run after a linearity run keeps the ready flags
    run_vec('{1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
    chk("R8 ready kept", rdata[27:22], 6'h3F);
    // R1: reset in the middle of a linearity run
    @(negedge clk);
    we = 1'b1; wdata = 32'h8001_0000; pw = 1'b1; en = 1'b0;
    @(negedge clk);
    we = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rdata after reset", rdata, 32'h0);
    chk("R1 calfact after reset", calfact, '0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule